// File: doc/BRIEF.md
# Timebase Timer with Update Event

This block is an up-counting timebase. A prescaler divides the clock, and every prescaler tick moves a counter forward. When the counter reaches the active reload value, it wraps to zero. That overflow raises an update event. The update event is driven out as a one-cycle trigger, so a neighbouring timer can use it as a capture strobe. It also sets a sticky flag.

Software writes the prescaler and reload values into preload registers. The running logic uses shadow copies of those values. The shadow copies take the preload values only on an update event, so a new period always starts cleanly at a boundary. An update can also come from a software update-generate bit or from an external slave reset pulse. A disable bit stops update events. With that bit set, a software update or a slave reset still restarts the counter and the prescaler.

Top module: `tbt_timebase`

## Requirements
- R1: After reset, cnt_o is 0, trgo_o and uif_o are 0, psc_act_o is 0 and arr_act_o is ARR_RST. The control bits and the preload registers are also cleared (preload reload value ARR_RST).
- R2: While the enable bit (address 0, bit 0) is 1, the prescaler counts 0..psc_act_o. On the cycle where it equals psc_act_o, the prescaler returns to 0 and the counter advances. The counter goes from arr_act_o to 0 and otherwise increments by 1. While the enable bit is 0, the counter and the prescaler hold.
- R3: With updates enabled, the counter wrapping from arr_act_o to 0 is an update event. trgo_o is high for exactly the cycle that follows each update-event edge, and only then.
- R4: Writing 1 to bit 2 of address 0 (update-generate) clears the counter and the prescaler on the next edge. It also raises an update event on that edge if updates are enabled. The bit clears itself, so one write gives one event.
- R5: A high cycle on slv_rst_i clears the counter and the prescaler on that edge. It also raises an update event if updates are enabled. This takes priority over a prescaler tick.
- R6: Writes to the preload registers (address 1 for the prescaler, address 2 for the reload) leave psc_act_o and arr_act_o unchanged. Those outputs take the preload values only on an update-event edge.
- R7: While the update-disable bit (address 0, bit 1) is 1, no update event occurs: no trgo_o pulse, no flag set and no shadow load. Update-generate and slv_rst_i still clear the counter and the prescaler.
- R8: uif_o is set on every update event. It stays set until a write to address 3 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it unchanged. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 prescaler preload, 2 reload preload, 3 status |
| wr_data_i | input | W | Write data |
| slv_rst_i | input | 1 | Slave reset pulse |
| cnt_o | output | W | Counter value |
| psc_act_o | output | W | Active (shadow) prescaler value |
| arr_act_o | output | W | Active (shadow) reload value |
| trgo_o | output | 1 | Update trigger pulse |
| uif_o | output | 1 | Sticky update flag |

## Verification
Two situations are hard to reach from the ports:
- An overflow, an update-generate and a slave reset land on the same edge while updates are disabled and a preload write is pending. This must give a restart with no event and no shadow load.
- A flag clear lands on the same edge as a new update event.

Random stimulus uses prescaler and reload values of 0 to 5, so events happen every few cycles. It toggles the disable bit and the reset input often. It also sends status writes with both bit-0 values. Directed sequences then force the disabled restart and the preload hold on purpose.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PSC  = 2'd1,
    ADDR_ARR  = 2'd2,
    ADDR_STAT = 2'd3
  } tbt_addr_e;

  localparam int unsigned CTRL_CEN  = 0;
  localparam int unsigned CTRL_UDIS = 1;
  localparam int unsigned CTRL_UG   = 2;
  localparam int unsigned STAT_UIF  = 0;
endpackage

// File: rtl/tbt_regs.sv
module tbt_regs import tbt_pkg::*; #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] ARR_RST = {W{1'b1}}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_ev_i,
  output logic         cen_o,
  output logic         udis_o,
  output logic         ug_o,
  output logic [W-1:0] psc_pre_o,
  output logic [W-1:0] arr_pre_o,
  output logic         uif_o
);
  logic wr_ctrl, wr_psc, wr_arr, wr_stat;
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_psc  = wr_en_i && (wr_addr_i == ADDR_PSC);
  assign wr_arr  = wr_en_i && (wr_addr_i == ADDR_ARR);
  assign wr_stat = wr_en_i && (wr_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_o     <= 1'b0;
      udis_o    <= 1'b0;
      ug_o      <= 1'b0;
      psc_pre_o <= '0;
      arr_pre_o <= ARR_RST;
      uif_o     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cen_o  <= wr_data_i[CTRL_CEN];
        udis_o <= wr_data_i[CTRL_UDIS];
      end
      // update-generate lives one cycle only
      ug_o <= wr_ctrl && wr_data_i[CTRL_UG];
      if (wr_psc) psc_pre_o <= wr_data_i;
      if (wr_arr) arr_pre_o <= wr_data_i;
      if (upd_ev_i) uif_o <= 1'b1;
      else if (wr_stat && !wr_data_i[STAT_UIF]) uif_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cen_i,
  input  logic         reinit_i,
  input  logic [W-1:0] psc_i,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  assign tick_o = cen_i && (pc_q == psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (reinit_i) pc_q <= '0;
    else if (tick_o)   pc_q <= '0;
    else if (cen_i)    pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         reinit_i,
  input  logic [W-1:0] arr_i,
  output logic         ovf_o,
  output logic [W-1:0] cnt_o
);
  assign ovf_o = tick_i && (cnt_o == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (reinit_i) cnt_o <= '0;
    else if (ovf_o)    cnt_o <= '0;
    else if (tick_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tbt_shadow.sv
module tbt_shadow #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] pre_i,
  output logic [W-1:0] act_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_o <= RST_VAL;
    else if (load_i) act_o <= pre_i;
  end
endmodule

// File: rtl/tbt_timebase.sv
module tbt_timebase #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] ARR_RST = {W{1'b1}}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_addr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         slv_rst_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] psc_act_o,
  output logic [W-1:0] arr_act_o,
  output logic         trgo_o,
  output logic         uif_o
);
  localparam int unsigned NSHD = 2;

  logic         cen, udis, ug_q, tick, ovf, reinit, upd_ev;
  logic [W-1:0] psc_pre, arr_pre;
  logic [W-1:0] pre_v [NSHD];
  logic [W-1:0] act_v [NSHD];

  assign reinit = ug_q || slv_rst_i;
  assign upd_ev = !udis && (ovf || reinit);

  tbt_regs #(.W(W), .ARR_RST(ARR_RST)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .upd_ev_i(upd_ev), .cen_o(cen), .udis_o(udis), .ug_o(ug_q),
    .psc_pre_o(psc_pre), .arr_pre_o(arr_pre), .uif_o(uif_o)
  );

  assign pre_v[0] = psc_pre;
  assign pre_v[1] = arr_pre;

  for (genvar i = 0; i < NSHD; i++) begin : g_shd
    localparam logic [W-1:0] RV = (i == 1) ? ARR_RST : '0;
    tbt_shadow #(.W(W), .RST_VAL(RV)) u_shd (
      .clk_i, .rst_ni, .load_i(upd_ev), .pre_i(pre_v[i]), .act_o(act_v[i])
    );
  end

  assign psc_act_o = act_v[0];
  assign arr_act_o = act_v[1];

  tbt_prescaler #(.W(W)) u_psc (
    .clk_i, .rst_ni, .cen_i(cen), .reinit_i(reinit),
    .psc_i(psc_act_o), .tick_o(tick)
  );

  tbt_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .reinit_i(reinit),
    .arr_i(arr_act_o), .ovf_o(ovf), .cnt_o(cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trgo_o <= 1'b0;
    else         trgo_o <= upd_ev;
  end
endmodule

// File: rtl/tbt_timebase_chk.sv
module tbt_timebase_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         slv_rst_i,
  input logic         cen,
  input logic         udis,
  input logic         ug_q,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] psc_act_o,
  input logic [W-1:0] arr_act_o,
  input logic         trgo_o,
  input logic         uif_o
);
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= arr_act_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen && !ug_q && !slv_rst_i) |=> $stable(cnt_o));
  a_r4_ug_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_q |=> (cnt_o == '0));
  a_r5_slave_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_rst_i |=> (cnt_o == '0));
  a_r6_shadow_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trgo_o |-> ($stable(psc_act_o) && $stable(arr_act_o)));
  a_r7_no_trgo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udis |=> !trgo_o);
  a_r8_flag_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trgo_o |-> uif_o);
endmodule

bind tbt_timebase tbt_timebase_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .slv_rst_i, .cen, .udis, .ug_q,
  .cnt_o, .psc_act_o, .arr_act_o, .trgo_o, .uif_o
);

// File: tb/sim_tbt_timebase.sv
module sim_tbt_timebase;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] ARR_RST = {W{1'b1}};

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, slv_rst_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] cnt_o, psc_act_o, arr_act_o;
  logic trgo_o, uif_o;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  tbt_timebase #(.W(W), .ARR_RST(ARR_RST)) u0 (.*);

  // reference state
  logic         m_cen, m_udis, m_ug, m_trgo, m_uif;
  logic [W-1:0] m_pc, m_cnt, m_psc_pre, m_arr_pre, m_psc, m_arr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cen <= 0; m_udis <= 0; m_ug <= 0; m_trgo <= 0; m_uif <= 0;
      m_pc <= 0; m_cnt <= 0; m_psc_pre <= 0; m_arr_pre <= ARR_RST;
      m_psc <= 0; m_arr <= ARR_RST;
    end else begin
      logic re, tk, ov, up;
      re = m_ug || slv_rst_i;
      tk = m_cen && (m_pc == m_psc);
      ov = tk && (m_cnt == m_arr);
      up = !m_udis && (ov || re);
      if (re) begin m_pc <= 0; m_cnt <= 0; end
      else if (tk) begin m_pc <= 0; m_cnt <= ov ? '0 : m_cnt + 1'b1; end
      else if (m_cen) m_pc <= m_pc + 1'b1;
      if (up) begin m_psc <= m_psc_pre; m_arr <= m_arr_pre; end
      m_trgo <= up;
      if (up) m_uif <= 1;
      else if (wr_en_i && wr_addr_i == 2'd3 && !wr_data_i[0]) m_uif <= 0;
      m_ug <= wr_en_i && wr_addr_i == 2'd0 && wr_data_i[2];
      if (wr_en_i && wr_addr_i == 2'd0) begin m_cen <= wr_data_i[0]; m_udis <= wr_data_i[1]; end
      if (wr_en_i && wr_addr_i == 2'd1) m_psc_pre <= wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd2) m_arr_pre <= wr_data_i;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk(cnt_o === m_cnt, "R2 cnt", cnt_o, m_cnt);
    chk(trgo_o === m_trgo, "R3 trgo", W'(trgo_o), W'(m_trgo));
    chk(uif_o === m_uif, "R8 uif", W'(uif_o), W'(m_uif));
    chk(psc_act_o === m_psc, "R6 psc_act", psc_act_o, m_psc);
    chk(arr_act_o === m_arr, "R6 arr_act", arr_act_o, m_arr);
  endtask

  // compare at negedge, then drive next inputs
  task automatic step(input bit we, input logic [1:0] a, input logic [W-1:0] d, input bit sr);
    @(negedge clk_i);
    cmp_all();
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; slv_rst_i = sr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cnt_o == 0 && !trgo_o && !uif_o, "R1 outputs", cnt_o, 0);
    chk(psc_act_o == 0 && arr_act_o == ARR_RST, "R1 shadows", arr_act_o, ARR_RST);
    rst_ni = 1'b1;

    // R6 preload writes without event keep active values
    step(1, 2'd1, 16'd1, 0);
    step(1, 2'd2, 16'd3, 0);
    idle(2);
    chk(psc_act_o == 0 && arr_act_o == ARR_RST, "R6 preload held", arr_act_o, ARR_RST);
    // R4 update-generate loads shadows and pulses
    step(1, 2'd0, 16'b101, 0);
    step(0, 0, 0, 0);
    idle(1);
    chk(arr_act_o == 3 && psc_act_o == 1, "R4 ug load", arr_act_o, 3);
    chk(uif_o == 1, "R8 flag set", W'(uif_o), 1);
    // R2 period (psc+1)*(arr+1)=8 cycles
    idle(20);
    // R8 clear with bit0=1 keeps flag
    step(1, 2'd3, 16'd1, 0);
    step(1, 2'd0, 16'b000, 0);
    idle(2);
    chk(uif_o == 1, "R8 keep on bit0=1", W'(uif_o), 1);
    step(1, 2'd3, 16'd0, 0);
    idle(2);
    chk(uif_o == 0, "R8 cleared", W'(uif_o), 0);
    // R2 disabled counter holds
    idle(5);
    // R7 disabled updates, ug and slave reset still clear
    step(1, 2'd0, 16'b011, 0);
    idle(5);
    step(1, 2'd2, 16'd9, 0);
    step(1, 2'd0, 16'b111, 0);
    idle(2);
    chk(cnt_o <= 1 && arr_act_o == 3 && !uif_o, "R7 ug restart no event", arr_act_o, 3);
    idle(3);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk(cnt_o == 0 && !trgo_o, "R7 R5 slave restart no event", cnt_o, 0);
    // R5 slave reset with updates enabled
    step(1, 2'd0, 16'b001, 0);
    idle(4);
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    chk(trgo_o == 1 && arr_act_o == 9, "R5 slave event", arr_act_o, 9);
    idle(2);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, sr;
      logic [1:0] a;
      logic [W-1:0] d;
      we = ($urandom % 4) == 0;
      a  = 2'($urandom % 4);
      sr = ($urandom % 32) == 0;
      case (a)
        2'd0: d = W'({($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 8) != 0});
        2'd3: d = W'($urandom % 2);
        default: d = W'($urandom % 6);
      endcase
      step(we, a, d, sr);
    end
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule